// File: doc/BRIEF.md
# PLL Reference Clock Switch Sequencer

This block changes which physical reference clock feeds a PLL. It does this by running a fixed series of accesses on a 32-bit memory-mapped reconfiguration bus. A start pulse carries a logical clock index. The sequencer first wins the bus through a simple request/grant pair. It then handles two reference selection muxes, one after the other. For each mux it fetches that mux's per-index lookup word and keeps only the low byte. It then reads the mux's select register, replaces that register's low byte with the fetched byte, and writes the word back.

When the write to the second select register is accepted, the block drops its bus request. On the next cycle it pulses done. An index that is not below the configured clock count is refused with a one-cycle error pulse, and no bus activity follows.

Top module: `refclk_switch_seq`

## Requirements
- R1: After a synchronous reset, done, error, busy, bus request, read and write outputs are all low.
- R2: A start with an index below NUM_REFCLK (default 5) raises busy and the bus request in the cycle after start. No read or write is issued before the grant input is high.
- R3: The accesses come in exactly this order: read 0x117+index, read 0x114, write 0x114, read 0x11D+index, read 0x11C, write 0x11C. These are the only six accesses.
- R4: Each select write carries bits [31:8] of the word just read from that select register, unchanged. Bits [7:0] are replaced with bits [7:0] of that mux's lookup word. The upper bits of the lookup word are not used.
- R5: A read or write stays asserted, with stable address and write data, for as long as the wait input is high. Read data is taken in the cycle the read is accepted, that is, the cycle in which the wait input is low.
- R6: The bus request falls in the cycle after the final write is accepted. Done is high for exactly one cycle, in the cycle after the request falls. Busy returns low together with done.
- R7: A start with index ≥ NUM_REFCLK gives a one-cycle error pulse in the next cycle. It raises no request, issues no read or write, and does not set busy.
- R8: A start pulse while a switch is in progress is ignored. The run in progress finishes with its original index, and no second run follows.
- R9: Read and write are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to switch the reference clock |
| idx_i | input | 3 | Logical reference clock index sampled with start |
| busy_o | output | 1 | A switch is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle out-of-range index pulse |
| bus_req_o | output | 1 | Bus ownership request |
| bus_gnt_i | input | 1 | Bus ownership grant |
| cfg_addr_o | output | 10 | Reconfiguration bus address |
| cfg_rd_o | output | 1 | Read command |
| cfg_wr_o | output | 1 | Write command |
| cfg_wdata_o | output | 32 | Write data |
| cfg_rdata_i | input | 32 | Read data |
| cfg_wait_i | input | 1 | Wait request: command not yet accepted |

## Verification
The assertions check the following on every cycle:
- read and write are never asserted together;
- commands are held while the wait input is high;
- no command appears without a request;
- writes go only to the two select addresses;
- done is a single-cycle pulse that follows the request release;
- an error pulse never coincides with bus activity.

Some behaviour only the bench scenarios can show. These are:
- the exact six-access order for each index;
- the merged byte and preserved upper bits that land in the register model;
- that nothing is issued before a delayed grant;
- that starts arriving mid-run or out of range leave no trace on the bus.

// File: rtl/refsw_pkg.sv
`timescale 1ns/1ps
package refsw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_LUT,
    ST_SEL_RD,
    ST_SEL_WR,
    ST_FIN
  } refsw_state_e;

  localparam int NUM_MUX = 2;
endpackage

// File: rtl/refsw_addr.sv
`timescale 1ns/1ps
module refsw_addr #(
  parameter int ADDR_W    = 10,
  parameter int IDX_W     = 3,
  parameter int NUM_MUX   = 2,
  parameter int LUT0_BASE = 'h117,
  parameter int LUT1_BASE = 'h11D,
  parameter int SEL0_ADDR = 'h114,
  parameter int SEL1_ADDR = 'h11C
) (
  input  logic [IDX_W-1:0]               idx_i,
  output logic [NUM_MUX-1:0][ADDR_W-1:0] lut_addr_o,
  output logic [NUM_MUX-1:0][ADDR_W-1:0] sel_addr_o
);
  for (genvar m = 0; m < NUM_MUX; m++) begin : g_mux
    localparam int LBASE = (m == 0) ? LUT0_BASE : LUT1_BASE;
    localparam int SADDR = (m == 0) ? SEL0_ADDR : SEL1_ADDR;
    assign lut_addr_o[m] = ADDR_W'(LBASE) + ADDR_W'(idx_i);
    assign sel_addr_o[m] = ADDR_W'(SADDR);
  end
endmodule

// File: rtl/refsw_merge.sv
`timescale 1ns/1ps
module refsw_merge #(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 8
) (
  input  logic [DATA_W-1:0]  word_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic [DATA_W-1:0]  merged_o
);
  if (FIELD_W < DATA_W) begin : g_keep_upper
    assign merged_o = {word_i[DATA_W-1:FIELD_W], field_i};
  end else begin : g_full
    assign merged_o = field_i[DATA_W-1:0];
  end
endmodule

// File: rtl/refsw_ctrl.sv
`timescale 1ns/1ps
module refsw_ctrl
  import refsw_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int FIELD_W    = 8,
  parameter int IDX_W      = 3,
  parameter int NUM_REFCLK = 5
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic                           gnt_i,
  input  logic                           wait_i,
  input  logic [DATA_W-1:0]              rdata_i,
  input  logic [NUM_MUX-1:0][ADDR_W-1:0] lut_addr_i,
  input  logic [NUM_MUX-1:0][ADDR_W-1:0] sel_addr_i,
  input  logic [DATA_W-1:0]              merged_i,
  output logic [IDX_W-1:0]               idx_o,
  output logic [FIELD_W-1:0]             field_o,
  output logic [ADDR_W-1:0]              addr_o,
  output logic                           rd_o,
  output logic                           wr_o,
  output logic [DATA_W-1:0]              wdata_o,
  output logic                           req_o,
  output logic                           busy_o,
  output logic                           done_o,
  output logic                           err_o
);
  localparam int MUX_W = (NUM_MUX > 1) ? $clog2(NUM_MUX) : 1;
  localparam logic [MUX_W-1:0] LAST_MUX = MUX_W'(NUM_MUX - 1);

  refsw_state_e     st;
  logic [MUX_W-1:0] mux_q;
  logic             idx_ok;
  logic             accept;

  assign idx_ok = (32'(idx_i) < NUM_REFCLK);
  assign accept = (rd_o || wr_o) && !wait_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      mux_q   <= '0;
      idx_o   <= '0;
      field_o <= '0;
      addr_o  <= '0;
      rd_o    <= 1'b0;
      wr_o    <= 1'b0;
      wdata_o <= '0;
      req_o   <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            if (idx_ok) begin
              idx_o  <= idx_i;
              mux_q  <= '0;
              req_o  <= 1'b1;
              busy_o <= 1'b1;
              st     <= ST_ARB;
            end else begin
              err_o <= 1'b1;
            end
          end
        end
        ST_ARB: begin
          if (gnt_i) begin
            rd_o   <= 1'b1;
            addr_o <= lut_addr_i[0];
            st     <= ST_LUT;
          end
        end
        ST_LUT: begin
          if (accept) begin
            field_o <= rdata_i[FIELD_W-1:0];
            addr_o  <= sel_addr_i[mux_q];
            st      <= ST_SEL_RD;
          end
        end
        ST_SEL_RD: begin
          if (accept) begin
            rd_o    <= 1'b0;
            wr_o    <= 1'b1;
            wdata_o <= merged_i;
            st      <= ST_SEL_WR;
          end
        end
        ST_SEL_WR: begin
          if (accept) begin
            wr_o <= 1'b0;
            if (mux_q == LAST_MUX) begin
              req_o <= 1'b0;
              st    <= ST_FIN;
            end else begin
              mux_q  <= mux_q + 1'b1;
              rd_o   <= 1'b1;
              addr_o <= lut_addr_i[mux_q + 1'b1];
              st     <= ST_LUT;
            end
          end
        end
        ST_FIN: begin
          done_o <= 1'b1;
          busy_o <= 1'b0;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  cmd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_o && wr_o));

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_o && wait_i) |=> (rd_o && $stable(addr_o)));

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_o && wait_i) |=> (wr_o && $stable(addr_o) && $stable(wdata_o)));

  // R2
  cmd_owned_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_o || wr_o) |-> (req_o && busy_o));

  // R3
  wr_target_chk: assert property (@(posedge clk) disable iff (rst)
    wr_o |-> ((addr_o == sel_addr_i[0]) || (addr_o == sel_addr_i[NUM_MUX-1])));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6
  rel_then_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(req_o) |=> done_o);

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!req_o && !rd_o && !wr_o && !busy_o));
endmodule

// File: rtl/refclk_switch_seq.sv
`timescale 1ns/1ps
module refclk_switch_seq #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int FIELD_W    = 8,
  parameter int IDX_W      = 3,
  parameter int NUM_REFCLK = 5,
  parameter int LUT0_BASE  = 'h117,
  parameter int LUT1_BASE  = 'h11D,
  parameter int SEL0_ADDR  = 'h114,
  parameter int SEL1_ADDR  = 'h11C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [ADDR_W-1:0] cfg_addr_o,
  output logic              cfg_rd_o,
  output logic              cfg_wr_o,
  output logic [DATA_W-1:0] cfg_wdata_o,
  input  logic [DATA_W-1:0] cfg_rdata_i,
  input  logic              cfg_wait_i
);
  localparam int NMUX = refsw_pkg::NUM_MUX;

  logic [IDX_W-1:0]            idx_q;
  logic [FIELD_W-1:0]          field_q;
  logic [NMUX-1:0][ADDR_W-1:0] lut_addr;
  logic [NMUX-1:0][ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0]           merged;

  refsw_addr #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_MUX(NMUX),
    .LUT0_BASE(LUT0_BASE), .LUT1_BASE(LUT1_BASE),
    .SEL0_ADDR(SEL0_ADDR), .SEL1_ADDR(SEL1_ADDR)
  ) u_addr (
    .idx_i      (idx_q),
    .lut_addr_o (lut_addr),
    .sel_addr_o (sel_addr)
  );

  refsw_merge #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_merge (
    .word_i   (cfg_rdata_i),
    .field_i  (field_q),
    .merged_o (merged)
  );

  refsw_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W),
    .IDX_W(IDX_W), .NUM_REFCLK(NUM_REFCLK)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .idx_i      (idx_i),
    .gnt_i      (bus_gnt_i),
    .wait_i     (cfg_wait_i),
    .rdata_i    (cfg_rdata_i),
    .lut_addr_i (lut_addr),
    .sel_addr_i (sel_addr),
    .merged_i   (merged),
    .idx_o      (idx_q),
    .field_o    (field_q),
    .addr_o     (cfg_addr_o),
    .rd_o       (cfg_rd_o),
    .wr_o       (cfg_wr_o),
    .wdata_o    (cfg_wdata_o),
    .req_o      (bus_req_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );
endmodule

// File: tb/refclk_switch_seq_test.sv
`timescale 1ns/1ps
module refclk_switch_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [2:0]  idx_i = '0;
  logic        busy_o, done_o, err_o, bus_req_o;
  logic        bus_gnt_i;
  logic [9:0]  cfg_addr_o;
  logic        cfg_rd_o, cfg_wr_o;
  logic [31:0] cfg_wdata_o, cfg_rdata_i;
  logic        cfg_wait_i;

  always #4 clk = ~clk;

  refclk_switch_seq uut (
    .clk(clk), .rst(rst), .start_i(start_i), .idx_i(idx_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
    .cfg_addr_o(cfg_addr_o), .cfg_rd_o(cfg_rd_o), .cfg_wr_o(cfg_wr_o),
    .cfg_wdata_o(cfg_wdata_o), .cfg_rdata_i(cfg_rdata_i), .cfg_wait_i(cfg_wait_i)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bus environment knobs driven by scenarios
  int wait_n = 0;
  int gnt_delay = 0;

  // register model and monitors
  logic [31:0] regs [0:1023];
  logic [9:0]  tr_addr [0:127];
  bit          tr_wr [0:127];
  int tr_n = 0, wcnt = 0, gcnt = 0, cyc = 0;
  int done_cnt = 0, err_cnt = 0, bad_wr = 0, early_cmd = 0;
  int t_lastwr = 0, t_rel = 0, t_done = 0;
  bit req_prev = 0;
  logic gnt_q = 1'b0;

  assign bus_gnt_i   = gnt_q;
  assign cfg_rdata_i = regs[cfg_addr_o];
  assign cfg_wait_i  = (cfg_rd_o || cfg_wr_o) && (wcnt < wait_n);

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int i = 0; i < 1024; i++) regs[i] <= 32'h0;
      for (int i = 0; i < 5; i++) begin
        regs['h117 + i] <= 32'hDEADBE00 | (32'hA0 + i);
        regs['h11D + i] <= 32'h77665500 | (32'h50 + i);
      end
      regs['h114] <= 32'h12345600;
      regs['h11C] <= 32'h9ABCDE00;
      wcnt <= 0; gcnt <= 0; gnt_q <= 1'b0; req_prev = 0;
    end else begin
      if (cfg_rd_o || cfg_wr_o) begin
        if (!gnt_q) early_cmd++;
        if (cfg_wait_i) wcnt <= wcnt + 1;
        else begin
          wcnt <= 0;
          if (tr_n < 128) begin
            tr_addr[tr_n] = cfg_addr_o;
            tr_wr[tr_n] = cfg_wr_o;
            tr_n++;
          end
          if (cfg_wr_o) begin
            regs[cfg_addr_o] <= cfg_wdata_o;
            if (cfg_addr_o != 10'h114 && cfg_addr_o != 10'h11C) bad_wr++;
            t_lastwr = cyc;
          end
        end
      end
      if (bus_req_o) begin
        gcnt <= gcnt + 1;
        gnt_q <= (gcnt >= gnt_delay);
      end else begin
        gcnt <= 0;
        gnt_q <= 1'b0;
      end
      if (req_prev && !bus_req_o) t_rel = cyc;
      req_prev = bus_req_o;
      if (done_o) begin done_cnt++; t_done = cyc; end
      if (err_o) err_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [2:0] idx);
    @(negedge clk);
    start_i = 1'b1;
    idx_i = idx;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    for (int k = 0; k < 400 && done_cnt == d0; k++) @(negedge clk);
  endtask

  task automatic check_trace(input int base, input int idx);
    logic [9:0] ea [0:5];
    bit ew [0:5];
    ea[0] = 10'h117 + 10'(idx); ew[0] = 0;
    ea[1] = 10'h114;            ew[1] = 0;
    ea[2] = 10'h114;            ew[2] = 1;
    ea[3] = 10'h11D + 10'(idx); ew[3] = 0;
    ea[4] = 10'h11C;            ew[4] = 0;
    ea[5] = 10'h11C;            ew[5] = 1;
    chk(tr_n - base == 6, "R3 access count", tr_n - base, 6);
    for (int k = 0; k < 6; k++) begin
      if (base + k < 128)
        chk(tr_addr[base + k] == ea[k] && tr_wr[base + k] == ew[k], "R3 access order",
            {tr_wr[base + k], tr_addr[base + k]}, {ew[k], ea[k]});
    end
    // R4: upper bits preserved, low byte from lookup
    chk(regs['h114] == {24'h123456, 8'hA0 + 8'(idx)}, "R4 select0 word",
        regs['h114], {24'h123456, 8'hA0 + 8'(idx)});
    chk(regs['h11C] == {24'h9ABCDE, 8'h50 + 8'(idx)}, "R4 select1 word",
        regs['h11C], {24'h9ABCDE, 8'h50 + 8'(idx)});
    chk(bad_wr == 0, "R3 stray write", bad_wr, 0);
  endtask

  // R2 R3 R4 R5 R6: one full switch
  task automatic t_switch(input int idx, input int wn, input int gd);
    int base, d0;
    wait_n = wn;
    gnt_delay = gd;
    base = tr_n;
    d0 = done_cnt;
    pulse_start(3'(idx));
    chk(busy_o && bus_req_o, "R2 busy/request after start", {busy_o, bus_req_o}, 2'b11);
    wait_done(d0);
    repeat (3) @(negedge clk);
    chk(done_cnt - d0 == 1, "R6 done pulses", done_cnt - d0, 1);
    chk(t_rel == t_lastwr + 1, "R6 release after last write", t_rel - t_lastwr, 1);
    chk(t_done == t_rel + 1, "R6 done after release", t_done - t_rel, 1);
    chk(!busy_o && !bus_req_o, "R6 idle after done", {busy_o, bus_req_o}, 0);
    chk(early_cmd == 0, "R2 command before grant", early_cmd, 0);
    check_trace(base, idx);
  endtask

  // R7
  task automatic t_bad_index(input int idx);
    int base, e0;
    base = tr_n;
    e0 = err_cnt;
    pulse_start(3'(idx));
    chk(err_o == 1'b1, "R7 error pulse", err_o, 1);
    chk(!busy_o && !bus_req_o, "R7 no request", {busy_o, bus_req_o}, 0);
    @(negedge clk);
    chk(err_o == 1'b0, "R7 error one cycle", err_o, 0);
    repeat (6) @(negedge clk);
    chk(err_cnt - e0 == 1, "R7 error count", err_cnt - e0, 1);
    chk(tr_n == base && !bus_req_o, "R7 no traffic", tr_n - base, 0);
  endtask

  // R8
  task automatic t_start_while_busy();
    int base, d0;
    wait_n = 1;
    gnt_delay = 2;
    base = tr_n;
    d0 = done_cnt;
    pulse_start(3'd1);
    repeat (4) @(negedge clk);
    start_i = 1'b1;
    idx_i = 3'd3;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(d0);
    repeat (12) @(negedge clk);
    chk(done_cnt - d0 == 1, "R8 single completion", done_cnt - d0, 1);
    chk(!busy_o && !bus_req_o, "R8 no second run", {busy_o, bus_req_o}, 0);
    check_trace(base, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk({done_o, err_o, busy_o, bus_req_o, cfg_rd_o, cfg_wr_o} == 6'b0, "R1 reset outputs",
        {done_o, err_o, busy_o, bus_req_o, cfg_rd_o, cfg_wr_o}, 0);
    t_switch(0, 0, 0);
    t_switch(3, 2, 3);
    t_switch(4, 3, 1);
    t_switch(2, 1, 5);
    t_bad_index(5);
    t_bad_index(7);
    t_start_while_busy();
    t_switch(1, 0, 2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule